// File: doc/BRIEF.md
# Byte-Wide Clocked Serial Port

This block moves one byte at a time over a three-wire synchronous link: serial clock, serial data out and serial data in. A single 8-bit shift register does both jobs. Bit 0 leaves first on the data output. At the same time, bits from the data input enter at the top of the register, so after a full transfer the register holds the received byte in the same order. Host software sees that byte as two 4-bit registers and starts a transfer by setting a go bit.

In master mode the block makes the serial clock itself. It divides the system clock by a parameterised amount, idles the clock high, drives exactly eight low pulses per byte, and enables its clock output driver. In slave mode the clock output driver is off. The block then follows a clock from the pin, passes it through a synchroniser, and raises a ready line so the external master knows a byte is waiting. The data output always changes on a rising serial clock edge. A configuration bit picks whether incoming data is sampled on the rising or the falling edge. When the eighth rising edge has been counted, a completion flag is set and a maskable interrupt follows from it.

Top module: `csi_port`

## Requirements
- R1: After reset, sclk_out is 1, irq and ready are 0, the completion flag (address 3 bit 0) reads 0, and both data nibbles read 0.
- R2: Address 0 reads and writes data bits 3:0 and address 1 reads and writes data bits 7:4. A nibble write made while a transfer runs is ignored.
- R3: Writing address 2 with bit 3 = 1 while idle starts a transfer. Address 2 bit 3 reads 1 while the transfer runs and 0 once it has ended. Address 2 bit 2 selects master mode (1) or slave mode (0).
- R4: In master mode sclk_oe is 1, and sclk_out idles high. Each transfer gives exactly 8 low pulses, and each half period lasts HALF_DIV system clocks.
- R5: Data leaves least significant bit first on sdo. sdo changes only on a rising serial clock edge.
- R6: Address 2 bit 1 = 1 samples sdi on the rising serial edge. With bit 1 = 0, sdi is sampled on the falling edge, so received bit k is the value that was present at falling edge k.
- R7: The flag is set on the eighth rising edge whether or not the interrupt is enabled. irq is 1 exactly when the flag is 1 and address 2 bit 0 (the interrupt enable) is 1.
- R8: Writing 1 to address 3 bit 0 clears the flag. Writing 0 leaves it set.
- R9: In slave mode sclk_oe is 0 and sclk_in drives the shift register. sclk_in edges seen while no transfer runs change neither the data nor the flag.
- R10: In slave mode, ready goes to 1 when the go bit is written and returns to 0 at the first serial clock edge of the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 low nibble, 1 high nibble, 2 control, 3 status) |
| bus_wdata | input | 4 | Register write data |
| bus_rdata | output | 4 | Register read data for bus_addr |
| sclk_in | input | 1 | Serial clock from pin (slave mode) |
| sclk_out | output | 1 | Serial clock to pin (master mode) |
| sclk_oe | output | 1 | Clock pin output enable, high in master mode |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output |
| ready | output | 1 | Slave-mode ready indication to the external master |
| irq | output | 1 | Completion interrupt, flag gated by enable |

## Verification
The bench sets the data input changing right after each falling edge. With that stimulus, a design that samples on the wrong edge returns the pattern shifted by one bit instead of as sent. It writes a nibble in the middle of a transfer, and a design that accepted the write would send corrupted upper bits. It runs one transfer with the interrupt disabled: the flag must still be set while irq stays low, and a design that gated the flag with the mask would show no completion at all. It also toggles the slave clock while idle, where a design that counted those edges would corrupt the byte or raise a false completion. It checks that ready drops at the first edge and not at the end of the transfer.

// File: rtl/csi_pkg.sv
// Shared constants and types for the clocked serial port.
// Assumes a fixed byte-wide transfer split into two host nibbles.
package csi_pkg;
    localparam int DATA_W = 8;
    localparam int NIB_W  = 4;
    localparam int ADDR_W = 2;

    // Host register addresses
    typedef enum logic [ADDR_W-1:0] {
        REG_LO   = 2'd0,
        REG_HI   = 2'd1,
        REG_CTRL = 2'd2,
        REG_STAT = 2'd3
    } reg_addr_e;

    // Control register bit positions
    localparam int CTL_IRQ_EN = 0;
    localparam int CTL_RISE   = 1;
    localparam int CTL_MASTER = 2;
    localparam int CTL_GO     = 3;
endpackage

// File: rtl/csi_regs.sv
// Host register file: control bits, completion flag, read mux.
// Assumes single-cycle writes; mode bits are frozen while busy.
module csi_regs
    import csi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NIB_W-1:0]  wdata_i,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic [DATA_W-1:0] shreg_i,
    output logic              master_o,
    output logic              rise_o,
    output logic              start_o,
    output logic              start_slave_o,
    output logic              lo_we_o,
    output logic              hi_we_o,
    output logic              irq_o,
    output logic [NIB_W-1:0]  rdata_o
);
    logic en_q, rise_q, master_q, flag_q;
    logic ctrl_we;

    // Decode write strobes
    always_comb begin
        ctrl_we       = we_i && (addr_i == REG_CTRL);
        start_o       = ctrl_we && wdata_i[CTL_GO] && !busy_i;
        start_slave_o = start_o && !wdata_i[CTL_MASTER];
        lo_we_o       = we_i && (addr_i == REG_LO) && !busy_i;
        hi_we_o       = we_i && (addr_i == REG_HI) && !busy_i;
    end

    // Control bits; mode and edge only change while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            rise_q   <= 1'b0;
            master_q <= 1'b0;
        end else if (ctrl_we) begin
            en_q <= wdata_i[CTL_IRQ_EN];
            if (!busy_i) begin
                rise_q   <= wdata_i[CTL_RISE];
                master_q <= wdata_i[CTL_MASTER];
            end
        end
    end

    // Completion flag: set wins over write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (done_i)
            flag_q <= 1'b1;
        else if (we_i && (addr_i == REG_STAT) && wdata_i[0])
            flag_q <= 1'b0;
    end

    // Read mux
    always_comb begin
        case (addr_i)
            REG_LO:   rdata_o = shreg_i[NIB_W-1:0];
            REG_HI:   rdata_o = shreg_i[DATA_W-1:NIB_W];
            REG_CTRL: rdata_o = {busy_i, master_q, rise_q, en_q};
            default:  rdata_o = {3'b000, flag_q};
        endcase
    end

    assign master_o = master_q;
    assign rise_o   = rise_q;
    assign irq_o    = flag_q && en_q;

    assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> flag_q);
    assert_go_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> busy_i);
endmodule

// File: rtl/csi_sclk.sv
// Serial clock source: master divider or synchronised slave clock,
// producing one-cycle rise/fall events and the sampled data bit.
// Assumes slave clock half period well above SYNC_STAGES+1 cycles.
module csi_sclk #(
    parameter int HALF_DIV    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    input  logic start_i,
    input  logic master_i,
    input  logic sclk_i,
    input  logic sdi_i,
    output logic sclk_o,
    output logic rise_ev_o,
    output logic fall_ev_o,
    output logic smp_bit_o
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

    logic [DIV_W-1:0]     div_q;
    logic                 sclk_q;
    logic                 tick;
    logic [SYNC_STAGES:0] ck_sync;
    logic [SYNC_STAGES-1:0] d_sync;
    logic                 slv_rise, slv_fall;

    assign tick = busy_i && master_i && (div_q == DIV_LAST);

    // Half-period divider, restarted at every trigger
    always_ff @(posedge clk) begin
        if (!rst_n || start_i || !busy_i)
            div_q <= '0;
        else if (div_q == DIV_LAST)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

    // Master clock: idle high, toggles on each divider tick
    always_ff @(posedge clk) begin
        if (!rst_n || !busy_i || !master_i)
            sclk_q <= 1'b1;
        else if (tick)
            sclk_q <= !sclk_q;
    end

    // Synchronisers for slave clock and data, equal depth keeps alignment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_sync <= '1;
            d_sync  <= '0;
        end else begin
            ck_sync <= {ck_sync[SYNC_STAGES-1:0], sclk_i};
            d_sync  <= {d_sync[SYNC_STAGES-2:0], sdi_i};
        end
    end

    assign slv_rise = ck_sync[SYNC_STAGES-1] && !ck_sync[SYNC_STAGES];
    assign slv_fall = !ck_sync[SYNC_STAGES-1] && ck_sync[SYNC_STAGES];

    // Event selection by mode
    always_comb begin
        if (master_i) begin
            rise_ev_o = tick && !sclk_q;
            fall_ev_o = tick && sclk_q;
            smp_bit_o = sdi_i;
        end else begin
            rise_ev_o = busy_i && slv_rise;
            fall_ev_o = busy_i && slv_fall;
            smp_bit_o = d_sync[SYNC_STAGES-1];
        end
    end

    assign sclk_o = sclk_q;

    assert_idle_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |-> sclk_q);
    assert_half_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && master_i && div_q != DIV_LAST) |=> $stable(sclk_q));
endmodule

// File: rtl/csi_shift.sv
// Byte shift register, bit counter, busy state and slave ready line.
// Shifts only on rising events; falling events latch the input bit
// when falling-edge sampling is selected.
module csi_shift
    import csi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              start_slave_i,
    input  logic              lo_we_i,
    input  logic              hi_we_i,
    input  logic [NIB_W-1:0]  wdata_i,
    input  logic              rise_ev_i,
    input  logic              fall_ev_i,
    input  logic              smp_bit_i,
    input  logic              rise_sel_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              ready_o,
    output logic [DATA_W-1:0] shreg_o,
    output logic              sdo_o
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

    logic              busy_q, ready_q, held_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] sh_q;
    logic              in_bit;

    assign in_bit = rise_sel_i ? smp_bit_i : held_q;
    assign done_o = busy_q && rise_ev_i && (cnt_q == CNT_LAST);

    // Transfer state: busy, count, ready
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            ready_q <= 1'b0;
        end else if (start_i) begin
            busy_q  <= 1'b1;
            cnt_q   <= '0;
            ready_q <= start_slave_i;
        end else if (busy_q) begin
            if (rise_ev_i || fall_ev_i)
                ready_q <= 1'b0;
            if (rise_ev_i) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CNT_LAST)
                    busy_q <= 1'b0;
            end
        end
    end

    // Falling-edge sample latch
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= 1'b0;
        else if (busy_q && fall_ev_i)
            held_q <= smp_bit_i;
    end

    // Shift register: host nibble loads while idle, shifts on rise
    always_ff @(posedge clk) begin
        if (!rst_n)
            sh_q <= '0;
        else if (busy_q && rise_ev_i)
            sh_q <= {in_bit, sh_q[DATA_W-1:1]};
        else begin
            if (lo_we_i) sh_q[NIB_W-1:0]      <= wdata_i;
            if (hi_we_i) sh_q[DATA_W-1:NIB_W] <= wdata_i;
        end
    end

    assign busy_o  = busy_q;
    assign ready_o = ready_q;
    assign shreg_o = sh_q;
    assign sdo_o   = sh_q[0];

    assert_sdo_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !rise_ev_i) |=> $stable(sdo_o));
    assert_ready_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ready_q |-> busy_q);
    assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_q);
endmodule

// File: rtl/csi_port.sv
// Top of the clocked serial port: wires register file, clock source
// and shift register. Pads and clock switching live outside.
module csi_port #(
    parameter int HALF_DIV    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_we,
    input  logic [1:0] bus_addr,
    input  logic [3:0] bus_wdata,
    output logic [3:0] bus_rdata,
    input  logic       sclk_in,
    output logic       sclk_out,
    output logic       sclk_oe,
    input  logic       sdi,
    output logic       sdo,
    output logic       ready,
    output logic       irq
);
    import csi_pkg::*;

    logic              master, rise_sel, start, start_slave, lo_we, hi_we;
    logic              busy, done, rise_ev, fall_ev, smp_bit;
    logic [DATA_W-1:0] shreg;

    csi_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(bus_we), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .busy_i(busy), .done_i(done), .shreg_i(shreg),
        .master_o(master), .rise_o(rise_sel), .start_o(start),
        .start_slave_o(start_slave), .lo_we_o(lo_we), .hi_we_o(hi_we),
        .irq_o(irq), .rdata_o(bus_rdata)
    );

    csi_sclk #(.HALF_DIV(HALF_DIV), .SYNC_STAGES(SYNC_STAGES)) u_sclk (
        .clk(clk), .rst_n(rst_n), .busy_i(busy), .start_i(start),
        .master_i(master), .sclk_i(sclk_in), .sdi_i(sdi), .sclk_o(sclk_out),
        .rise_ev_o(rise_ev), .fall_ev_o(fall_ev), .smp_bit_o(smp_bit)
    );

    csi_shift u_shift (
        .clk(clk), .rst_n(rst_n), .start_i(start), .start_slave_i(start_slave),
        .lo_we_i(lo_we), .hi_we_i(hi_we), .wdata_i(bus_wdata),
        .rise_ev_i(rise_ev), .fall_ev_i(fall_ev), .smp_bit_i(smp_bit),
        .rise_sel_i(rise_sel), .busy_o(busy), .done_o(done), .ready_o(ready),
        .shreg_o(shreg), .sdo_o(sdo)
    );

    assign sclk_oe = master;
endmodule

// File: tb/tb_csi_port.sv
module tb_csi_port;
    localparam int HALF = 2;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd3;
    logic [3:0] bus_wdata = 4'd0;
    logic [3:0] bus_rdata;
    logic       sclk_in = 1'b1, sdi = 1'b0;
    logic       sclk_out, sclk_oe, sdo, ready, irq;

    int n_chk = 0, n_fail = 0;
    bit cmp_irq = 1'b1;

    // Reference model state
    bit m_busy, m_sclk = 1'b1, m_flag, m_en;
    int m_n, m_rises;

    csi_port #(.HALF_DIV(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk_in(sclk_in),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdi(sdi), .sdo(sdo),
        .ready(ready), .irq(irq)
    );

    always #10 clk = !clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Behavioural model of master-mode timing and the flag
    always @(posedge clk) begin
        bit pre, set_f;
        if (!rst_n) begin
            m_busy = 0; m_sclk = 1; m_flag = 0; m_en = 0; m_n = 0; m_rises = 0;
        end else begin
            pre = m_busy;
            set_f = 0;
            if (m_busy) begin
                m_n++;
                if (m_n % HALF == 0) begin
                    m_sclk = !m_sclk;
                    if (m_sclk) begin
                        m_rises++;
                        if (m_rises == 8) begin m_busy = 0; set_f = 1; end
                    end
                end
            end
            if (bus_we && bus_addr == 2'd3 && bus_wdata[0] && !set_f) m_flag = 0;
            if (set_f) m_flag = 1;
            if (bus_we && bus_addr == 2'd2) begin
                m_en = bus_wdata[0];
                if (!pre && bus_wdata[3] && bus_wdata[2]) begin
                    m_busy = 1; m_n = 0; m_rises = 0;
                end
            end
        end
    end

    // Per-cycle comparison against the model (R4 clock shape, R7 irq)
    always @(negedge clk) begin
        if (rst_n) begin
            chk(sclk_out == m_sclk, "R4 sclk_out", sclk_out, m_sclk);
            if (cmp_irq) chk(irq == (m_flag && m_en), "R7 irq", irq, m_flag && m_en);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [3:0] d);
        @(negedge clk);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 0; bus_addr = 2'd3;
    endtask

    task automatic rd(input logic [1:0] a, output logic [3:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd_byte(output logic [7:0] b);
        logic [3:0] lo, hi;
        rd(2'd0, lo);
        rd(2'd1, hi);
        b = {hi, lo};
    endtask

    // Master transfer with sdi changed right after each falling edge
    task automatic run_master(input logic [7:0] tx, input logic [7:0] pat,
                              input bit rise, input bit en, input bit init,
                              input bit poke);
        logic [7:0] txc, rx, exp_rx;
        logic [3:0] v;
        bit prev;
        int falls, cyc, last_fall;
        txc = 0; falls = 0; cyc = 0; last_fall = 0;
        sdi = init;
        wr(2'd0, tx[3:0]);
        wr(2'd1, tx[7:4]);
        rd_byte(rx);
        chk(rx == tx, "R2 nibble readback", rx, tx);
        wr(2'd2, {1'b1, 1'b1, rise, en});
        prev = sclk_out;
        for (int i = 0; i < HALF * 16 + 8; i++) begin
            @(negedge clk);
            cyc++;
            bus_we = 0; bus_addr = 2'd3;
            if (i == 0) chk(sclk_oe == 1, "R4 sclk_oe master", sclk_oe, 1);
            if (prev && !sclk_out) begin
                if (falls > 0)
                    chk(cyc - last_fall == 2 * HALF, "R4 period", cyc - last_fall, 2 * HALF);
                last_fall = cyc;
                if (falls < 8) txc[falls] = sdo;
                if (falls < 8) sdi = pat[falls];
                if (poke && falls == 3) begin
                    bus_we = 1; bus_addr = 2'd0; bus_wdata = 4'hF;
                end
                falls++;
            end
            prev = sclk_out;
        end
        chk(falls == 8, "R4 pulse count", falls, 8);
        chk(txc == tx, "R5 lsb-first tx", txc, tx);
        exp_rx = rise ? pat : {pat[6:0], init};
        rd_byte(rx);
        chk(rx == exp_rx, "R6 rx byte", rx, exp_rx);
        rd(2'd2, v);
        chk(v[3] == 0, "R3 go self-clears", v[3], 0);
        rd(2'd3, v);
        chk(v[0] == 1, "R7 flag set", v[0], 1);
        chk(irq == en, "R7 irq gating", irq, en);
    endtask

    // Slave transfer; bench is the external master
    task automatic run_slave(input logic [7:0] tx, input logic [7:0] pat,
                             input bit rise, input bit init);
        logic [7:0] txc, rx, exp_rx;
        logic [3:0] v;
        txc = 0;
        sdi = init;
        cmp_irq = 0;
        wr(2'd0, tx[3:0]);
        wr(2'd1, tx[7:4]);
        wr(2'd2, {1'b1, 1'b0, rise, 1'b0});
        chk(ready == 1, "R10 ready after go", ready, 1);
        chk(sclk_oe == 0, "R9 sclk_oe slave", sclk_oe, 0);
        for (int k = 0; k < 8; k++) begin
            sclk_in = 0;
            repeat (3) @(negedge clk);
            if (k == 0) chk(ready == 0, "R10 ready drops at first edge", ready, 0);
            sdi = pat[k];
            repeat (3) @(negedge clk);
            txc[k] = sdo;
            sclk_in = 1;
            repeat (6) @(negedge clk);
        end
        chk(txc == tx, "R5 slave tx", txc, tx);
        exp_rx = rise ? pat : {pat[6:0], init};
        rd_byte(rx);
        chk(rx == exp_rx, "R6 slave rx", rx, exp_rx);
        rd(2'd3, v);
        chk(v[0] == 1, "R9 slave flag", v[0], 1);
        chk(ready == 0, "R10 ready idle", ready, 0);
        wr(2'd3, 4'h1);
        rd(2'd3, v);
        chk(v[0] == 0, "R8 clear after slave", v[0], 0);
        cmp_irq = 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        logic [3:0] v;
        logic [7:0] b;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(sclk_out == 1, "R1 sclk_out", sclk_out, 1);
        chk(irq == 0, "R1 irq", irq, 0);
        chk(ready == 0, "R1 ready", ready, 0);
        rd(2'd3, v);
        chk(v == 0, "R1 flag", v, 0);
        rd_byte(b);
        chk(b == 0, "R1 data", b, 0);

        // Master, rising sample, irq enabled, mid-transfer write (R2 ignored)
        run_master(8'hA5, 8'h3C, 1'b1, 1'b1, 1'b0, 1'b1);
        // R8: writing 0 keeps the flag, writing 1 clears it
        wr(2'd3, 4'h0);
        rd(2'd3, v);
        chk(v[0] == 1, "R8 write 0 keeps", v[0], 1);
        wr(2'd3, 4'h1);
        rd(2'd3, v);
        chk(v[0] == 0, "R8 write 1 clears", v[0], 0);
        chk(irq == 0, "R8 irq low", irq, 0);

        // Master, falling sample, irq masked: flag still set (R7)
        run_master(8'h5A, 8'hC3, 1'b0, 1'b0, 1'b1, 1'b0);
        wr(2'd3, 4'h1);

        // Slave, rising and falling sample
        run_slave(8'h96, 8'h4B, 1'b1, 1'b0);
        run_slave(8'h3E, 8'hD2, 1'b0, 1'b1);

        // R9: slave clock edges while idle are ignored
        wr(2'd0, 4'h7);
        wr(2'd1, 4'h2);
        wr(2'd2, 4'b0000);
        for (int k = 0; k < 3; k++) begin
            sdi = 1; sclk_in = 0;
            repeat (5) @(negedge clk);
            sclk_in = 1;
            repeat (5) @(negedge clk);
        end
        rd_byte(b);
        chk(b == 8'h27, "R9 idle edges keep data", b, 8'h27);
        rd(2'd3, v);
        chk(v[0] == 0, "R9 idle edges no flag", v[0], 0);
        chk(ready == 0, "R9 idle ready", ready, 0);

        summary();
    end
endmodule